// File: doc/BRIEF.md
# SDRAM Burst Command Sequencer

This block turns single user transfer requests into the command sequence that a four-bank, 32-bit synchronous DRAM expects. Each request carries a direction, a bank, a row, a column, an auto-precharge wish and, for full-page mode, a word count. For every request the block opens the row with ACTIVATE. It waits the row-to-column delay, then issues READ or WRITE and moves the burst. It closes the bank either with an explicit PRECHARGE or by the device's own auto-precharge, and then waits out the precharge time. Write words pass from the user port to the DQ output in the cycles of the burst. Read words are sampled a programmable CAS latency (2 or 3) after the READ and handed back with a valid strobe.

Timing parameters (row-to-column delay, precharge time, CAS latency, burst mode of 4 words or full page) are static configuration inputs. They are copied into the block only when a request is accepted, so changing them mid-transfer has no effect. Power-up, mode-register load and refresh are handled elsewhere. On the command pins, (RAS#, CAS#, WE#) is 0,1,1 for ACTIVATE, 1,0,1 for READ, 1,0,0 for WRITE, 0,1,0 for PRECHARGE and 1,1,1 for NOP. Chip select stays low.

The controller is a Moore machine with the states IDLE, ACT, RCD_WAIT, RD_CMD, RD_BURST, WR_CMD, WR_BURST, PRE, TRP_WAIT and AP_WAIT. Its transitions are as follows:
- IDLE to ACT on an accepted request.
- ACT to RCD_WAIT when tRCD exceeds 1, otherwise straight to RD_CMD or WR_CMD.
- RCD_WAIT to the command state when its count runs out.
- The command state to its burst state when the burst exceeds one word, otherwise to the tail.
- The burst state to the tail when the burst ends. The tail is AP_WAIT when auto-precharge is in effect, otherwise PRE.
- PRE to TRP_WAIT when tRP exceeds 1, otherwise to IDLE.
- TRP_WAIT to IDLE, and AP_WAIT to IDLE, when their counts run out.

Top module: `sdram_burst_seq`

## Requirements
- R1: During and right after reset the block shows NOP on the command pins with chip select low, req_ready high, DQ output enable low, wr_ack low and rd_valid low.
- R2: A request accepted in cycle t (req_valid and req_ready high) yields ACTIVATE in cycle t+1, with the request's bank on sd_ba and its row on sd_addr. req_ready stays low from t+1 until the transfer's wait ends.
- R3: READ or WRITE is issued exactly tRCD cycles after the ACTIVATE (a tRCD of 0 counts as 1). The column is on sd_addr[7:0], address bit 10 carries the auto-precharge flag, and the other address bits are zero.
- R4: In a write, sd_dq_oe and wr_ack are high from the WRITE cycle for the burst length, and sd_dq_out equals wr_data in those cycles. In every other cycle, including all of a read, sd_dq_oe and wr_ack are low.
- R5: With cfg_cas3 low (latency 2) or high (latency 3), read word j is sampled from sd_dq_in at the end of cycle READ+latency+j. It appears on rd_data with rd_valid high one cycle later, and rd_valid is low in all other cycles.
- R6: The burst length is 4 words when cfg_full_page is low and req_len+1 words when it is high.
- R7: Without auto-precharge, PRECHARGE (address bit 10 low, request's bank on sd_ba) comes exactly burst-length cycles after the READ/WRITE, and req_ready returns tRP cycles after the PRECHARGE.
- R8: With auto-precharge in 4-word mode, address bit 10 is high on the READ/WRITE. Only NOPs follow until req_ready returns burst-length plus tRP cycles after the command.
- R9: In full-page mode the auto-precharge flag is ignored. Address bit 10 is low and an explicit PRECHARGE ends the burst as in R7.
- R10: Configuration inputs and request fields are taken only at acceptance. Changes to them during a transfer do not alter that transfer's commands, data timing or wait lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trcd | input | 4 | Row-to-column delay in cycles |
| cfg_trp | input | 4 | Precharge time in cycles |
| cfg_cas3 | input | 1 | 0: CAS latency 2, 1: CAS latency 3 |
| cfg_full_page | input | 1 | 0: 4-word bursts, 1: full-page bursts |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken when high together with req_valid |
| req_write | input | 1 | 1: write, 0: read |
| req_autopre | input | 1 | Ask for auto-precharge |
| req_bank | input | 2 | Bank |
| req_row | input | 12 | Row address |
| req_col | input | 8 | Starting column |
| req_len | input | 8 | Full-page word count minus one |
| wr_data | input | 32 | Write word for the current cycle |
| wr_ack | output | 1 | wr_data consumed this cycle |
| rd_data | output | 32 | Captured read word |
| rd_valid | output | 1 | rd_data valid |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Address bus |
| sd_dq_out | output | 32 | DQ drive value |
| sd_dq_oe | output | 1 | DQ output enable |
| sd_dq_in | input | 32 | DQ sampled value |

## Verification
Every result has a fixed distance from acceptance in cycle t:
- ACTIVATE lands at t+1 and the column command at c = t+1+tRCD.
- Write words go out in cycles c to c+L-1.
- Read word j is driven by the bench model in cycle c+CL+j and expected on rd_valid in c+CL+j+1.
- PRECHARGE comes at c+L, and req_ready returns at c+L+tRP.

The bench sweeps tRCD and tRP over 1 to 3, both latencies, both burst modes, both directions and both auto-precharge settings. It builds the full expected pin picture for every cycle from these formulas. It drives inputs at the falling edge and compares one time step later, so each comparison lands in the exact cycle the formula names. After acceptance it scrambles the configuration and request inputs to show that they are ignored.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ACT,
        S_RCD_WAIT,
        S_RD_CMD,
        S_RD_BURST,
        S_WR_CMD,
        S_WR_BURST,
        S_PRE,
        S_TRP_WAIT,
        S_AP_WAIT
    } seq_state_t;

    // {ras_n, cas_n, we_n}
    typedef logic [2:0] sd_cmd_t;

    localparam sd_cmd_t CMD_NOP = 3'b111;
    localparam sd_cmd_t CMD_ACT = 3'b011;
    localparam sd_cmd_t CMD_RD  = 3'b101;
    localparam sd_cmd_t CMD_WR  = 3'b100;
    localparam sd_cmd_t CMD_PRE = 3'b010;

    localparam int MIN_CL = 2;
    localparam int MAX_CL = 3;

endpackage

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
    import sdram_seq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int TIM_W  = 4,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIM_W-1:0]  cfg_trcd,
    input  logic [TIM_W-1:0]  cfg_trp,
    input  logic              cfg_cas3,
    input  logic              cfg_full_page,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_autopre,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [COL_W-1:0]  req_len,
    output seq_state_t        state,
    output logic              req_ready,
    output logic [BANK_W-1:0] bank_q,
    output logic [ROW_W-1:0]  row_q,
    output logic [COL_W-1:0]  col_q,
    output logic              ap_q,
    output logic [1:0]        cl_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [TIM_W-1:0] TIM_ONE = TIM_W'(1);

    seq_state_t        state_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic              wr_q;
    logic [TIM_W-1:0]  trcd_q, trp_q;
    logic [COL_W-1:0]  blen_m1_q;
    logic              accept;

    assign accept    = (state == S_IDLE) && req_valid;
    assign req_ready = (state == S_IDLE);

    // state register and request/config capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt       <= '0;
            bank_q    <= '0;
            row_q     <= '0;
            col_q     <= '0;
            wr_q      <= 1'b0;
            ap_q      <= 1'b0;
            cl_q      <= 2'd2;
            trcd_q    <= TIM_ONE;
            trp_q     <= TIM_ONE;
            blen_m1_q <= COL_W'(3);
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            if (accept) begin
                bank_q    <= req_bank;
                row_q     <= req_row;
                col_q     <= req_col;
                wr_q      <= req_write;
                ap_q      <= req_autopre && !cfg_full_page;
                cl_q      <= cfg_cas3 ? 2'd3 : 2'd2;
                trcd_q    <= (cfg_trcd == '0) ? TIM_ONE : cfg_trcd;
                trp_q     <= (cfg_trp == '0) ? TIM_ONE : cfg_trp;
                blen_m1_q <= cfg_full_page ? req_len : COL_W'(3);
            end
        end
    end

    // next state and wait counter
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            S_IDLE: begin
                if (req_valid) state_n = S_ACT;
            end
            S_ACT: begin
                if (trcd_q > TIM_ONE) begin
                    state_n = S_RCD_WAIT;
                    cnt_n   = CNT_W'(trcd_q) - ONE;
                end else begin
                    state_n = wr_q ? S_WR_CMD : S_RD_CMD;
                end
            end
            S_RCD_WAIT: begin
                if (cnt == ONE) state_n = wr_q ? S_WR_CMD : S_RD_CMD;
                else            cnt_n   = cnt - ONE;
            end
            S_RD_CMD, S_WR_CMD: begin
                if (blen_m1_q != '0) begin
                    state_n = (state == S_WR_CMD) ? S_WR_BURST : S_RD_BURST;
                    cnt_n   = CNT_W'(blen_m1_q);
                end else if (ap_q) begin
                    state_n = S_AP_WAIT;
                    cnt_n   = CNT_W'(trp_q);
                end else begin
                    state_n = S_PRE;
                end
            end
            S_RD_BURST, S_WR_BURST: begin
                if (cnt == ONE) begin
                    if (ap_q) begin
                        state_n = S_AP_WAIT;
                        cnt_n   = CNT_W'(trp_q);
                    end else begin
                        state_n = S_PRE;
                    end
                end else begin
                    cnt_n = cnt - ONE;
                end
            end
            S_PRE: begin
                if (trp_q > TIM_ONE) begin
                    state_n = S_TRP_WAIT;
                    cnt_n   = CNT_W'(trp_q) - ONE;
                end else begin
                    state_n = S_IDLE;
                end
            end
            S_TRP_WAIT, S_AP_WAIT: begin
                if (cnt == ONE) state_n = S_IDLE;
                else            cnt_n   = cnt - ONE;
            end
        endcase
    end

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
    import sdram_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10
) (
    input  seq_state_t        state,
    input  logic [BANK_W-1:0] bank_q,
    input  logic [ROW_W-1:0]  row_q,
    input  logic [COL_W-1:0]  col_q,
    input  logic              ap_q,
    input  logic [DATA_W-1:0] wr_data,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    output logic              wr_ack,
    output logic              rd_slot
);

    sd_cmd_t cmd;

    assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_dq_out = sd_dq_oe ? wr_data : '0;

    // output decode from state
    always_comb begin
        cmd      = CMD_NOP;
        sd_ba    = '0;
        sd_addr  = '0;
        sd_dq_oe = 1'b0;
        wr_ack   = 1'b0;
        rd_slot  = 1'b0;
        unique case (state)
            S_IDLE, S_RCD_WAIT, S_TRP_WAIT, S_AP_WAIT: begin
            end
            S_ACT: begin
                cmd     = CMD_ACT;
                sd_ba   = bank_q;
                sd_addr = ADDR_W'(row_q);
            end
            S_RD_CMD: begin
                cmd                  = CMD_RD;
                sd_ba                = bank_q;
                sd_addr[COL_W-1:0]   = col_q;
                sd_addr[AP_BIT]      = ap_q;
                rd_slot              = 1'b1;
            end
            S_RD_BURST: begin
                rd_slot = 1'b1;
            end
            S_WR_CMD: begin
                cmd                  = CMD_WR;
                sd_ba                = bank_q;
                sd_addr[COL_W-1:0]   = col_q;
                sd_addr[AP_BIT]      = ap_q;
                sd_dq_oe             = 1'b1;
                wr_ack               = 1'b1;
            end
            S_WR_BURST: begin
                sd_dq_oe = 1'b1;
                wr_ack   = 1'b1;
            end
            S_PRE: begin
                cmd   = CMD_PRE;
                sd_ba = bank_q;
            end
        endcase
    end

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture
    import sdram_seq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_slot,
    input  logic [1:0]        cl_q,
    input  logic [DATA_W-1:0] sd_dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int N_LAT = MAX_CL - MIN_CL + 1;

    logic [N_LAT-1:0] taps;

    // one delay line per supported latency; the slot enters only the
    // line matching the latency latched for its transfer
    for (genvar g = MIN_CL; g <= MAX_CL; g++) begin : g_lat
        logic [g-1:0] line;
        always_ff @(posedge clk) begin
            if (!rst_n) line <= '0;
            else        line <= {line[g-2:0], rd_slot && (cl_q == 2'(g))};
        end
        assign taps[g-MIN_CL] = line[g-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= |taps;
            if (|taps) rd_data <= sd_dq_in;
        end
    end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 8,
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10,
    parameter int TIM_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIM_W-1:0]  cfg_trcd,
    input  logic [TIM_W-1:0]  cfg_trp,
    input  logic              cfg_cas3,
    input  logic              cfg_full_page,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_autopre,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [COL_W-1:0]  req_len,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);

    localparam int CNT_W = ((COL_W > TIM_W) ? COL_W : TIM_W) + 1;

    seq_state_t        state;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              ap_q;
    logic [1:0]        cl_q;
    logic              rd_slot;

    assign sd_cs_n = 1'b0;

    sdram_seq_ctrl #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .TIM_W(TIM_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_trcd     (cfg_trcd),
        .cfg_trp      (cfg_trp),
        .cfg_cas3     (cfg_cas3),
        .cfg_full_page(cfg_full_page),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_autopre  (req_autopre),
        .req_bank     (req_bank),
        .req_row      (req_row),
        .req_col      (req_col),
        .req_len      (req_len),
        .state        (state),
        .req_ready    (req_ready),
        .bank_q       (bank_q),
        .row_q        (row_q),
        .col_q        (col_q),
        .ap_q         (ap_q),
        .cl_q         (cl_q)
    );

    sdram_cmd_drive #(
        .DATA_W(DATA_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
        .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
    ) u_drive (
        .state    (state),
        .bank_q   (bank_q),
        .row_q    (row_q),
        .col_q    (col_q),
        .ap_q     (ap_q),
        .wr_data  (wr_data),
        .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n),
        .sd_we_n  (sd_we_n),
        .sd_ba    (sd_ba),
        .sd_addr  (sd_addr),
        .sd_dq_out(sd_dq_out),
        .sd_dq_oe (sd_dq_oe),
        .wr_ack   (wr_ack),
        .rd_slot  (rd_slot)
    );

    sdram_rd_capture #(
        .DATA_W(DATA_W)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_slot (rd_slot),
        .cl_q    (cl_q),
        .sd_dq_in(sd_dq_in),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
    parameter int TIM_W  = 4,
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TIM_W-1:0]  cfg_trcd,
    input logic [TIM_W-1:0]  cfg_trp,
    input logic              cfg_full_page,
    input logic              req_valid,
    input logic              req_ready,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              sd_dq_oe
);

    localparam int SAT_W = 8;
    localparam logic [SAT_W-1:0] SAT_MAX = '1;
    localparam logic [TIM_W-1:0] TIM_ONE = TIM_W'(1);

    logic [2:0]       cmd;
    logic             is_act, is_rd, is_wr, is_pre, is_ap;
    logic [TIM_W-1:0] trcd_l, trp_l, pre_trp, ap_trp;
    logic             fp_l;
    logic [SAT_W-1:0] since_act, since_pre, since_ap;

    assign cmd    = {sd_ras_n, sd_cas_n, sd_we_n};
    assign is_act = (cmd == 3'b011);
    assign is_rd  = (cmd == 3'b101);
    assign is_wr  = (cmd == 3'b100);
    assign is_pre = (cmd == 3'b010);
    assign is_ap  = (is_rd || is_wr) && sd_addr[AP_BIT];

    // independent cycle counters since each kind of command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trcd_l    <= TIM_ONE;
            trp_l     <= TIM_ONE;
            pre_trp   <= TIM_ONE;
            ap_trp    <= TIM_ONE;
            fp_l      <= 1'b0;
            since_act <= '0;
            since_pre <= SAT_MAX;
            since_ap  <= SAT_MAX;
        end else begin
            if (req_valid && req_ready) begin
                trcd_l <= (cfg_trcd == '0) ? TIM_ONE : cfg_trcd;
                trp_l  <= (cfg_trp == '0) ? TIM_ONE : cfg_trp;
                fp_l   <= cfg_full_page;
            end
            if (is_act)                    since_act <= SAT_W'(1);
            else if (since_act != SAT_MAX) since_act <= since_act + SAT_W'(1);
            if (is_pre) begin
                since_pre <= SAT_W'(1);
                pre_trp   <= trp_l;
            end else if (since_pre != SAT_MAX) begin
                since_pre <= since_pre + SAT_W'(1);
            end
            if (is_ap) begin
                since_ap <= SAT_W'(1);
                ap_trp   <= trp_l;
            end else if (since_ap != SAT_MAX) begin
                since_ap <= since_ap + SAT_W'(1);
            end
        end
    end

    // R1
    cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cs_n);

    // R2
    act_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> !req_ready);

    // R3
    rcd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd || is_wr) |-> (since_act >= SAT_W'(trcd_l)));

    // R4
    wr_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |-> sd_dq_oe);

    // R4
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> !sd_dq_oe);

    // R7
    trp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> (since_pre > SAT_W'(pre_trp)));

    // R8
    ap_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act || is_pre || (is_rd && !is_ap) || (is_wr && !is_ap))
            |-> (since_ap >= SAT_W'(ap_trp) + SAT_W'(4)));

    // R9
    fp_no_ap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_l && (is_rd || is_wr)) |-> !sd_addr[AP_BIT]);

endmodule

bind sdram_burst_seq sdram_seq_chk i_seq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_trcd     (cfg_trcd),
    .cfg_trp      (cfg_trp),
    .cfg_full_page(cfg_full_page),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .sd_cs_n      (sd_cs_n),
    .sd_ras_n     (sd_ras_n),
    .sd_cas_n     (sd_cas_n),
    .sd_we_n      (sd_we_n),
    .sd_addr      (sd_addr),
    .sd_dq_oe     (sd_dq_oe)
);

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_trcd = 4'd1;
    logic [3:0]  cfg_trp = 4'd1;
    logic        cfg_cas3 = 1'b0;
    logic        cfg_full_page = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_autopre = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic [7:0]  req_len = '0;
    logic [31:0] wr_data = '0;
    logic        wr_ack;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [31:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [31:0] sd_dq_in = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sdram_burst_seq i_sdram_burst_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp),
        .cfg_cas3(cfg_cas3), .cfg_full_page(cfg_full_page),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_autopre(req_autopre),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_len(req_len), .wr_data(wr_data), .wr_ack(wr_ack),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s at %0t: actual=%h expected=%h", tag, what, $time, act, exp);
        end
    endtask

    function automatic logic [31:0] wpat(input int id, input int i);
        return {id[15:0], 8'hC3, i[7:0]};
    endfunction

    function automatic logic [31:0] rpat(input int id, input int i);
        return {id[15:0], 8'h5A, i[7:0]};
    endfunction

    task automatic run_txn(input int wr, input int fp, input int ap, input int trcd,
                           input int trp, input int cl3, input int len, input int id);
        int L, c, cl, ap_eff, tail_end, kend;
        logic [1:0]  bank;
        logic [11:0] row;
        logic [7:0]  col;
        logic [2:0]  cmd, cmd_exp;
        logic [11:0] addr_exp;
        bit oe_exp, rv_exp;
        string tag;

        L        = fp ? len + 1 : 4;
        c        = 1 + trcd;
        cl       = cl3 ? 3 : 2;
        ap_eff   = (ap != 0 && fp == 0) ? 1 : 0;
        tail_end = c + L + trp;
        kend     = (tail_end > c + cl + L + 1) ? tail_end : c + cl + L + 1;
        bank     = 2'(id % 4);
        row      = 12'((id * 37) % 4096);
        col      = 8'((id * 13) % 256);

        @(negedge clk);
        cfg_trcd      = 4'(trcd);
        cfg_trp       = 4'(trp);
        cfg_cas3      = cl3[0];
        cfg_full_page = fp[0];
        req_write     = wr[0];
        req_autopre   = ap[0];
        req_bank      = bank;
        req_row       = row;
        req_col       = col;
        req_len       = 8'(len);
        req_valid     = 1'b1;
        #1;
        check(req_ready == 1'b1, "R2", "ready before accept", 32'(req_ready), 32'd1);

        for (int k = 1; k <= kend; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (k == 2) begin
                // R10: scramble everything after acceptance
                cfg_trcd      = ~cfg_trcd;
                cfg_trp       = ~cfg_trp;
                cfg_cas3      = ~cfg_cas3;
                cfg_full_page = ~cfg_full_page;
                req_write     = ~req_write;
                req_autopre   = ~req_autopre;
                req_bank      = ~req_bank;
                req_row       = ~req_row;
                req_col       = ~req_col;
                req_len       = ~req_len;
            end
            oe_exp  = (wr != 0) && (k >= c) && (k <= c + L - 1);
            wr_data = oe_exp ? wpat(id, k - c) : 32'h0BAD_F00D;
            if (wr == 0 && k >= c + cl && k <= c + cl + L - 1)
                sd_dq_in = rpat(id, k - c - cl);
            else
                sd_dq_in = 32'hFFFF_0000 ^ 32'(k);
            #1;

            cmd = {sd_ras_n, sd_cas_n, sd_we_n};
            if (k == 1) begin
                cmd_exp = 3'b011; tag = "R2";
            end else if (k == c) begin
                cmd_exp = wr ? 3'b100 : 3'b101; tag = "R3";
            end else if (k == c + L && ap_eff == 0) begin
                cmd_exp = 3'b010; tag = fp ? "R9" : "R7";
            end else begin
                cmd_exp = 3'b111; tag = ap_eff ? "R8" : "R6";
            end
            check(cmd == cmd_exp, tag, "command", 32'(cmd), 32'(cmd_exp));
            check(sd_cs_n == 1'b0, "R1", "chip select", 32'(sd_cs_n), 32'd0);

            if (k == 1) begin
                check(sd_ba == bank, "R2", "ACT bank", 32'(sd_ba), 32'(bank));
                check(sd_addr == row, "R10", "ACT row", 32'(sd_addr), 32'(row));
            end
            if (k == c) begin
                addr_exp = {1'b0, ap_eff[0], 2'b00, col};
                check(sd_ba == bank, "R3", "column bank", 32'(sd_ba), 32'(bank));
                check(sd_addr == addr_exp, fp ? "R9" : (ap ? "R8" : "R3"),
                      "column address", 32'(sd_addr), 32'(addr_exp));
            end
            if (k == c + L && ap_eff == 0) begin
                check(sd_ba == bank, "R7", "precharge bank", 32'(sd_ba), 32'(bank));
                check(sd_addr[10] == 1'b0, "R7", "precharge A10", 32'(sd_addr[10]), 32'd0);
            end

            check(sd_dq_oe == oe_exp, fp ? "R6" : "R4", "dq enable", 32'(sd_dq_oe), 32'(oe_exp));
            check(wr_ack == oe_exp, "R4", "wr_ack", 32'(wr_ack), 32'(oe_exp));
            if (oe_exp)
                check(sd_dq_out == wpat(id, k - c), "R4", "dq out", sd_dq_out, wpat(id, k - c));

            rv_exp = (wr == 0) && (k >= c + cl + 1) && (k <= c + cl + L);
            check(rd_valid == rv_exp, fp ? "R6" : "R5", "rd_valid", 32'(rd_valid), 32'(rv_exp));
            if (rv_exp)
                check(rd_data == rpat(id, k - c - cl - 1), "R5", "rd_data",
                      rd_data, rpat(id, k - c - cl - 1));

            check(req_ready == (k >= tail_end), ap_eff ? "R8" : "R7", "ready",
                  32'(req_ready), 32'(k >= tail_end));
        end
    endtask

    initial begin
        int id;
        id = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1: values held in reset
        check(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'd1);
        check({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1", "reset NOP",
              32'({sd_ras_n, sd_cas_n, sd_we_n}), 32'h7);
        check(sd_cs_n == 1'b0, "R1", "reset cs", 32'(sd_cs_n), 32'd0);
        check(sd_dq_oe == 1'b0, "R1", "reset oe", 32'(sd_dq_oe), 32'd0);
        check(rd_valid == 1'b0, "R1", "reset rd_valid", 32'(rd_valid), 32'd0);
        check(wr_ack == 1'b0, "R1", "reset wr_ack", 32'(wr_ack), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);

        for (int wr = 0; wr < 2; wr++)
            for (int fp = 0; fp < 2; fp++)
                for (int ap = 0; ap < 2; ap++)
                    for (int trcd = 1; trcd <= 3; trcd++)
                        for (int trp = 1; trp <= 3; trp++)
                            for (int cl3 = 0; cl3 < 2; cl3++)
                                for (int ls = 0; ls < (fp ? 2 : 1); ls++) begin
                                    id++;
                                    run_txn(wr, fp, ap, trcd, trp, cl3, ls ? 6 : 0, id);
                                end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule